// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer with Vacant-State Predictor

This block predicts the direction and destination of branches at fetch time. A direct-mapped table is indexed by the low bits of the instruction address above the alignment bits, and each slot holds an address tag, a branch destination and a 2-bit confidence state. A lookup port returns, in the same cycle, whether the fetch address has a live slot, whether it is predicted taken, and the stored destination. A separate resolve port reports each branch's real outcome and destination and trains the table.

No separate valid bit is kept: a slot whose state is zero is treated as empty. Because of this, a taken branch whose slot is at state zero, or that has no slot, is installed directly at the strongest taken state rather than stepping up one level. Resolve results are held for one cycle in an in-flight register before they are written to the table. A lookup or a second resolve of the same branch in that cycle reads the in-flight state instead of the table. On that path the counter behaves as a plain saturating counter, so zero steps to one.

Top module: `bpred_btb`

## Requirements
- R1: An address with no live slot (tag mismatch or state zero) gives `lk_hit`=0, `lk_taken`=0 and `lk_target`=0.
- R2: A taken resolve of a branch without a live slot (and not on the in-flight path) installs it with state 3, so it reads back as hit and taken.
- R3: State 0 is the vacant encoding: a branch trained down to state 0 reads as a miss, and its next taken resolve (off the in-flight path) sets state 3, not 1.
- R4: A live slot predicts taken in states 2 and 3 and not taken in state 1 (`lk_hit`=1, `lk_taken`=0).
- R5: A taken resolve on a live slot adds one and saturates at 3; a not-taken resolve subtracts one and saturates at 0.
- R6: A resolve takes effect on the lookup port in the following cycle. A resolve of the same address in the cycle right after a previous resolve starts from the in-flight state and counts symmetrically, so state 0 goes to 1 on taken.
- R7: The slot index is `pc[ALIGN_W+IDX_W-1:ALIGN_W]` and the tag is the bits above it. A tag mismatch is a miss, and a taken resolve on a miss overwrites the slot and evicts the previous owner.
- R8: A not-taken resolve on a miss writes nothing: the slot's current owner keeps its state and destination.
- R9: A taken resolve always stores the resolved destination; a not-taken resolve on a hit keeps the stored one.
- R10: Reset leaves every slot vacant, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_hit | output | 1 | Fetch address has a live slot |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | PC_W | Predicted destination, zero on miss |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome: 1 taken, 0 not taken |
| up_target | input | PC_W | Actual destination of the resolved branch |

## Verification
The bench targets the asymmetry around state zero. A design that steps a taken branch from a zero slot to state 1 would report a hit that is not taken where the bench expects taken. In the opposite direction, a design that applied the vacant rule on the in-flight path would report taken right after a back-to-back resolve that should leave the branch at state 1. Saturation at both ends is driven past its limit: a counter that wraps would flip the prediction after the extra step. Two tags that share one index check that a not-taken resolve on a miss leaves the other branch intact and that a taken one evicts it. A reference model, updated every clock, follows long mixed sequences on a small address pool so that conflicts and back-to-back resolves happen often.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        ST_VACANT    = 2'd0,
        ST_WEAK_NT   = 2'd1,
        ST_WEAK_TK   = 2'd2,
        ST_STRONG_TK = 2'd3
    } bp_state_e;

    function automatic bp_state_e st_up(input bp_state_e s);
        return (s == ST_STRONG_TK) ? ST_STRONG_TK : bp_state_e'(2'(s) + 2'd1);
    endfunction

    function automatic bp_state_e st_down(input bp_state_e s);
        return (s == ST_VACANT) ? ST_VACANT : bp_state_e'(2'(s) - 2'd1);
    endfunction

    function automatic logic st_live(input bp_state_e s);
        return s != ST_VACANT;
    endfunction

    function automatic logic st_taken(input bp_state_e s);
        return s[1];
    endfunction

    // Table path: zero and empty are the same, so a taken miss lands at the top.
    function automatic bp_state_e st_cold(input logic hit, input logic tk, input bp_state_e s);
        if (tk) return hit ? st_up(s) : ST_STRONG_TK;
        return hit ? st_down(s) : ST_VACANT;
    endfunction

    // In-flight path: plain saturating counter.
    function automatic bp_state_e st_warm(input logic tk, input bp_state_e s);
        return tk ? st_up(s) : st_down(s);
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import bpred_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  bp_state_e        wr_state,
    input  logic [TGT_W-1:0] wr_target,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [TAG_W-1:0] ra_tag,
    output bp_state_e        ra_state,
    output logic [TGT_W-1:0] ra_target,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [TAG_W-1:0] rb_tag,
    output bp_state_e        rb_state,
    output logic [TGT_W-1:0] rb_target
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [DEPTH];
    bp_state_e        st_q  [DEPTH];
    logic [TGT_W-1:0] tgt_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[e] <= '0;
                st_q[e]  <= ST_VACANT;
                tgt_q[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                tag_q[e] <= wr_tag;
                st_q[e]  <= wr_state;
                tgt_q[e] <= wr_target;
            end
        end
    end

    assign ra_tag    = tag_q[ra_idx];
    assign ra_state  = st_q[ra_idx];
    assign ra_target = tgt_q[ra_idx];
    assign rb_tag    = tag_q[rb_idx];
    assign rb_state  = st_q[rb_idx];
    assign rb_target = tgt_q[rb_idx];

endmodule

// File: rtl/btb_fwd.sv
module btb_fwd
    import bpred_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int TGT_W = 32
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic [TAG_W-1:0] t_tag,
    input  bp_state_e        t_state,
    input  logic [TGT_W-1:0] t_target,
    input  logic             p_vld,
    input  logic             p_we,
    input  logic [IDX_W-1:0] p_idx,
    input  logic [TAG_W-1:0] p_tag,
    input  bp_state_e        p_state,
    input  logic [TGT_W-1:0] p_target,
    output logic             e_hit,
    output bp_state_e        e_state,
    output logic [TGT_W-1:0] e_target,
    output logic             byp
);
    logic             use_p;
    logic [TAG_W-1:0] e_tag;

    always_comb begin
        use_p    = p_vld && p_we && (p_idx == idx);
        e_tag    = use_p ? p_tag    : t_tag;
        e_state  = use_p ? p_state  : t_state;
        e_target = use_p ? p_target : t_target;
        e_hit    = (e_tag == tag) && st_live(e_state);
        byp      = p_vld && (p_idx == idx) && (p_tag == tag);
    end

endmodule

// File: rtl/btb_next.sv
module btb_next
    import bpred_pkg::*;
#(
    parameter int TGT_W = 32
) (
    input  logic             tk,
    input  logic [TGT_W-1:0] res_target,
    input  logic             byp,
    input  bp_state_e        p_state,
    input  logic             p_we,
    input  logic             e_hit,
    input  bp_state_e        e_state,
    input  logic [TGT_W-1:0] e_target,
    output bp_state_e        n_state,
    output logic             n_we,
    output logic [TGT_W-1:0] n_target
);
    always_comb begin
        if (byp) begin
            n_state = st_warm(tk, p_state);
            n_we    = tk || p_we;
        end else begin
            n_state = st_cold(e_hit, tk, e_state);
            n_we    = tk || e_hit;
        end
        n_target = tk ? res_target : e_target;
    end

endmodule

// File: rtl/btb_inflight.sv
module btb_inflight
    import bpred_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic             in_we,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [TAG_W-1:0] in_tag,
    input  bp_state_e        in_state,
    input  logic [TGT_W-1:0] in_target,
    output logic             p_vld,
    output logic             p_we,
    output logic [IDX_W-1:0] p_idx,
    output logic [TAG_W-1:0] p_tag,
    output bp_state_e        p_state,
    output logic [TGT_W-1:0] p_target
);
    always_ff @(posedge clk) begin
        if (rst) begin
            p_vld    <= 1'b0;
            p_we     <= 1'b0;
            p_idx    <= '0;
            p_tag    <= '0;
            p_state  <= ST_VACANT;
            p_target <= '0;
        end else begin
            p_vld    <= in_vld;
            p_we     <= in_vld && in_we;
            p_idx    <= in_idx;
            p_tag    <= in_tag;
            p_state  <= in_state;
            p_target <= in_target;
        end
    end

endmodule

// File: rtl/bpred_btb.sv
module bpred_btb
    import bpred_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int ALIGN_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target
);
    localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

    logic [IDX_W-1:0] l_idx, u_idx, p_idx;
    logic [TAG_W-1:0] l_tag, u_tag, p_tag, ta_tag, tb_tag;
    bp_state_e        ta_st, tb_st, p_st, l_st, u_st, n_st;
    logic [PC_W-1:0]  ta_tgt, tb_tgt, p_tgt, l_tgt, u_tgt, n_tgt;
    logic             p_vld, p_we, l_hit, l_byp, u_hit, u_byp, n_we;

    assign l_idx = lk_pc[ALIGN_W +: IDX_W];
    assign l_tag = lk_pc[PC_W-1 -: TAG_W];
    assign u_idx = up_pc[ALIGN_W +: IDX_W];
    assign u_tag = up_pc[PC_W-1 -: TAG_W];

    btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(p_vld && p_we), .wr_idx(p_idx), .wr_tag(p_tag),
        .wr_state(p_st), .wr_target(p_tgt),
        .ra_idx(l_idx), .ra_tag(ta_tag), .ra_state(ta_st), .ra_target(ta_tgt),
        .rb_idx(u_idx), .rb_tag(tb_tag), .rb_state(tb_st), .rb_target(tb_tgt)
    );

    btb_fwd #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) u_fwd_lk (
        .idx(l_idx), .tag(l_tag),
        .t_tag(ta_tag), .t_state(ta_st), .t_target(ta_tgt),
        .p_vld(p_vld), .p_we(p_we), .p_idx(p_idx), .p_tag(p_tag),
        .p_state(p_st), .p_target(p_tgt),
        .e_hit(l_hit), .e_state(l_st), .e_target(l_tgt), .byp(l_byp)
    );

    btb_fwd #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) u_fwd_up (
        .idx(u_idx), .tag(u_tag),
        .t_tag(tb_tag), .t_state(tb_st), .t_target(tb_tgt),
        .p_vld(p_vld), .p_we(p_we), .p_idx(p_idx), .p_tag(p_tag),
        .p_state(p_st), .p_target(p_tgt),
        .e_hit(u_hit), .e_state(u_st), .e_target(u_tgt), .byp(u_byp)
    );

    btb_next #(.TGT_W(PC_W)) u_next (
        .tk(up_taken), .res_target(up_target),
        .byp(u_byp), .p_state(p_st), .p_we(p_we),
        .e_hit(u_hit), .e_state(u_st), .e_target(u_tgt),
        .n_state(n_st), .n_we(n_we), .n_target(n_tgt)
    );

    btb_inflight #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) u_inflight (
        .clk(clk), .rst(rst),
        .in_vld(up_valid), .in_we(n_we), .in_idx(u_idx), .in_tag(u_tag),
        .in_state(n_st), .in_target(n_tgt),
        .p_vld(p_vld), .p_we(p_we), .p_idx(p_idx), .p_tag(p_tag),
        .p_state(p_st), .p_target(p_tgt)
    );

    assign lk_hit    = l_hit;
    assign lk_taken  = l_hit && st_taken(l_st);
    assign lk_target = l_hit ? l_tgt : '0;

    // R4: a taken prediction needs a live slot
    a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
        lk_taken |-> lk_hit);

    // R1: a miss never exposes a destination
    a_r1_miss_no_target: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_target == '0);

    // R2: first taken resolve off the in-flight path installs at the top state
    a_r2_first_taken_strong: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && !u_byp && !u_hit) |=> (p_we && p_st == ST_STRONG_TK));

    // R8: not-taken resolve on a miss writes nothing
    a_r8_nt_miss_no_alloc: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_taken && !u_byp && !u_hit) |=> !p_we);

    // R6: in-flight path steps from zero to one on taken
    a_r6_bypass_warm: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && u_byp && p_st == ST_VACANT) |=> p_st == ST_WEAK_NT);

    // R6: lookup of the in-flight branch reflects the in-flight state
    a_r6_lookup_inflight: assert property (@(posedge clk) disable iff (rst)
        (l_byp && p_we) |-> (lk_hit == (p_st != ST_VACANT)));

    // R5: saturation at the top on the in-flight path
    a_r5_sat_top: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && u_byp && p_st == ST_STRONG_TK) |=> p_st == ST_STRONG_TK);

    // R9: a taken resolve carries its destination
    a_r9_target_kept: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken) |=> p_tgt == $past(up_target));

endmodule

// File: tb/tb_bpred_btb.sv
module tb_bpred_btb;
    localparam int PC_W = 32;
    localparam int IDX_W = 4;
    localparam int ALIGN_W = 2;
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PC_W-1:0] lk_pc = '0;
    logic lk_hit, lk_taken;
    logic [PC_W-1:0] lk_target;
    logic up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic up_taken = 1'b0;
    logic [PC_W-1:0] up_target = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bpred_btb #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
        .lk_target(lk_target), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .up_target(up_target)
    );

    always #2 clk = ~clk;

    // Behavioural reference model
    logic [TAG_W-1:0] m_tag [DEPTH];
    int               m_st  [DEPTH];
    logic [PC_W-1:0]  m_tgt [DEPTH];
    bit               pv_vld;
    logic [PC_W-1:0]  pv_pc;
    int               pv_st;
    bit               pv_we;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_tag[i] = '0; m_st[i] = 0; m_tgt[i] = '0;
            end
            pv_vld = 0;
        end else if (up_valid) begin
            int ix, ns;
            bit we, hit;
            ix = int'(up_pc[ALIGN_W +: IDX_W]);
            if (pv_vld && pv_pc == up_pc) begin
                ns = up_taken ? ((pv_st == 3) ? 3 : pv_st + 1) : ((pv_st == 0) ? 0 : pv_st - 1);
                we = up_taken || pv_we;
            end else begin
                hit = (m_tag[ix] == up_pc[PC_W-1 -: TAG_W]) && (m_st[ix] != 0);
                if (up_taken) ns = hit ? ((m_st[ix] == 3) ? 3 : m_st[ix] + 1) : 3;
                else          ns = hit ? m_st[ix] - 1 : 0;
                we = up_taken || hit;
            end
            if (we) begin
                m_tag[ix] = up_pc[PC_W-1 -: TAG_W];
                m_st[ix] = ns;
                if (up_taken) m_tgt[ix] = up_target;
            end
            pv_vld = 1; pv_pc = up_pc; pv_st = ns; pv_we = we;
        end else begin
            pv_vld = 0;
        end
    end

    // Per-cycle comparison with the model, away from the clock edge
    always begin
        @(negedge clk);
        #1;
        if (!rst && !done) begin
            int ix;
            bit eh, et;
            logic [PC_W-1:0] eg;
            ix = int'(lk_pc[ALIGN_W +: IDX_W]);
            eh = (m_tag[ix] == lk_pc[PC_W-1 -: TAG_W]) && (m_st[ix] != 0);
            et = eh && (m_st[ix] >= 2);
            eg = eh ? m_tgt[ix] : '0;
            checks++;
            if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
                failures++;
                $display("FAIL R5/R6/R7 model pc=%h got hit=%b tk=%b tgt=%h exp hit=%b tk=%b tgt=%h",
                         lk_pc, lk_hit, lk_taken, lk_target, eh, et, eg);
            end
        end
    end

    function automatic logic [PC_W-1:0] mkpc(input int tg, input int ix);
        return {TAG_W'(tg), IDX_W'(ix), ALIGN_W'(0)};
    endfunction

    task automatic drive(input logic [PC_W-1:0] lk, input logic uv,
                         input logic [PC_W-1:0] upc, input logic ut, input logic [PC_W-1:0] utg);
        @(negedge clk);
        lk_pc = lk; up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
    endtask

    task automatic idle(input logic [PC_W-1:0] lk);
        drive(lk, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic look(input string req, input logic eh, input logic et, input logic [PC_W-1:0] eg);
        #2;
        checks++;
        if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
            failures++;
            $display("FAIL %s pc=%h got hit=%b tk=%b tgt=%h exp hit=%b tk=%b tgt=%h",
                     req, lk_pc, lk_hit, lk_taken, lk_target, eh, et, eg);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] a, b, c, t1, t2;
        logic [31:0] seed;
        logic [PC_W-1:0] lastpc;
        a = mkpc(5, 3); b = mkpc(9, 3); c = mkpc(5, 4);
        t1 = 32'h1000_0040; t2 = 32'h2000_0080;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(a); look("R10 R1 reset miss", 0, 0, '0);

        drive(a, 1, a, 1, t1);
        idle(a); look("R6 lookup of in-flight", 1, 1, t1);
        idle(a); look("R2 first taken strong", 1, 1, t1);

        drive(a, 1, a, 0, '0); idle(a); look("R4 state 2 taken", 1, 1, t1);
        drive(a, 1, a, 0, '0); idle(a); look("R4 R9 state 1 not taken, target kept", 1, 0, t1);
        drive(a, 1, a, 0, '0); idle(a); look("R3 state 0 reads vacant", 0, 0, '0);
        drive(a, 1, a, 1, t1); idle(a); look("R3 zero jumps to 3", 1, 1, t1);

        drive(a, 1, a, 1, t1); idle(a);
        drive(a, 1, a, 1, t1); idle(a);
        drive(a, 1, a, 0, '0); idle(a);
        drive(a, 1, a, 0, '0); idle(a); look("R5 saturates at 3", 1, 0, t1);
        drive(a, 1, a, 0, '0); idle(a);
        drive(a, 1, a, 0, '0); idle(a); look("R5 saturates at 0", 0, 0, '0);

        drive(a, 1, a, 1, t1); idle(a);
        drive(a, 1, a, 0, '0); idle(a);
        drive(a, 1, a, 0, '0); idle(a);
        drive(a, 1, a, 0, '0);
        drive(a, 1, a, 1, t1);
        idle(a); idle(a); look("R6 in-flight zero to one", 1, 0, t1);

        drive(a, 1, a, 1, t2); idle(a); look("R9 new target stored", 1, 1, t2);

        idle(b); look("R7 tag mismatch misses", 0, 0, '0);
        idle(c); look("R7 other index misses", 0, 0, '0);
        drive(a, 1, b, 0, '0); idle(a); look("R8 not-taken miss keeps owner", 1, 1, t2);
        drive(b, 1, b, 1, t1); idle(b); look("R7 taken miss overwrites", 1, 1, t1);
        idle(a); look("R7 previous owner evicted", 0, 0, '0);

        seed = 32'h1234_5678;
        lastpc = a;
        for (int n = 0; n < 4000; n++) begin
            logic [PC_W-1:0] upc, lpc;
            seed = seed * 32'd1664525 + 32'd1013904223;
            upc = (seed[3:2] != 0) ? lastpc : mkpc(1 + int'(seed[9:8] % 2'd3), int'(seed[11:10]));
            lpc = seed[12] ? upc : mkpc(1 + int'(seed[14:13] % 2'd3), int'(seed[16:15]));
            drive(lpc, seed[20:18] != 0, upc, seed[21], {seed[31:24], 24'h0000_40});
            lastpc = upc;
        end

        drive(a, 0, '0, 0, '0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int t = 1; t <= 3; t++) begin
            for (int i = 0; i < 4; i++) begin
                idle(mkpc(t, i)); look("R10 reset clears", 0, 0, '0);
            end
        end

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule